// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns the peripheral clock into a one-cycle enable pulse at sixteen times the serial bit rate. The pulse period in clock cycles equals a 16-bit divisor. For a clock `f` and a wanted rate `B`, the divisor is round(f / (16·B)). For example, 868 gives about 9600 baud from a 133.33 MHz clock. The serial transmit and receive engines use the pulse as their oversampling enable.

Software reaches the divisor through two byte-wide registers. They are only visible while the divisor-access flag is set: offset 0 holds the low byte and offset 1 holds the high byte. A write to either byte restarts the count at once with the new value. A divisor of zero stops the pulse, and zero is the value after reset. While the serial engines report that they are idle, the pulse is held off to save power.

The control is a three-state machine:
- `BT_STOPPED`: the divisor is zero.
- `BT_PARKED`: the divisor is non-zero but the engines are idle.
- `BT_RUNNING`: the counter counts down.

The transitions are:
- STOPPED→PARKED: a non-zero divisor is written while the engines are idle.
- STOPPED→RUNNING: a non-zero divisor is written while the engines are active.
- PARKED→RUNNING: the engines leave idle.
- RUNNING→PARKED: the engines go idle.
- Any state→STOPPED: the divisor becomes zero.

In RUNNING, the down-counter reloads from the divisor when it reaches 1 and when a divisor write is accepted. Entering RUNNING always loads a full count.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor reads back as zero on both offsets and `tick` is low.
- R2: While the divisor is zero, `tick` stays low whatever `engines_idle` does.
- R3: With divisor D ≥ 1 and the engines active, `tick` is a one-cycle pulse that repeats every D cycles. With D = 1 it is high in every cycle.
- R4: If `engines_idle` is sampled low at rising edge E after being high, the first pulse is high in the cycle that follows the D-th rising edge, counting E as the first. Later pulses follow every D cycles.
- R5: If `engines_idle` is sampled high at a rising edge, `tick` is low in the following cycle.
- R6: A write is accepted when `wr_en` and `dla_en` are both high. An accepted write at rising edge W loads the new divisor and restarts the phase: the next pulse follows the D-th edge counting W as the first.
- R7: With `dla_en` high, `reg_sel` = 0 selects the divisor bits 7:0 and `reg_sel` = 1 selects bits 15:8, for both writes and `rd_data`. With `dla_en` low, `rd_data` is zero.
- R8: A write strobe with `dla_en` low changes neither the divisor nor the phase of the running pulse train.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dla_en | input | 1 | Divisor-access flag; exposes the divisor bytes |
| wr_en | input | 1 | Byte write strobe |
| reg_sel | input | 1 | Byte offset: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte written to the selected divisor byte |
| engines_idle | input | 1 | High while both serial engines have nothing to do |
| rd_data | output | 8 | Readback of the selected divisor byte |
| tick | output | 1 | One-cycle 16x-baud enable pulse |

## Verification
`rd_data` depends only on the divisor register and the select inputs, so it is valid in the cycle right after the write edge. `tick` is a registered Moore output. After a release edge or an accepted write edge, the first pulse is due in the cycle after the D-th rising edge, counting that edge as the first. The bench applies every input just after a falling edge and reads outputs at the next falling edge. It counts rising edges from the restart and expects a pulse exactly when that count is a multiple of D. The bench sweeps divisors 1 to 24 and several wider values, and it restarts the phase in the middle of a count.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BT_STOPPED = 2'd0,
        BT_PARKED  = 2'd1,
        BT_RUNNING = 2'd2
    } bt_state_e;

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
    import baud_tick_pkg::*;
#(
    parameter  int DIV_W = 16,
    localparam int NB    = DIV_W / BYTE_W,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dla_en,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [DIV_W-1:0]    div_q,
    output logic [DIV_W-1:0]    div_next,
    output logic                wr_hit,
    output logic [BYTE_W-1:0]   rd_data
);

    logic [NB-1:0] lane_hit;

    // One write-enable and next-value path per byte lane
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign lane_hit[b] = wr_en && dla_en && (reg_sel == SEL_W'(b));
        assign div_next[b*BYTE_W +: BYTE_W] =
            lane_hit[b] ? wr_data : div_q[b*BYTE_W +: BYTE_W];
    end

    assign wr_hit = |lane_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_next;
        end
    end

    // Readback mux; hidden while the access flag is clear
    always_comb begin
        rd_data = '0;
        if (dla_en) begin
            for (int b = 0; b < NB; b++) begin
                if (reg_sel == SEL_W'(b)) begin
                    rd_data = div_q[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/baud_tick_fsm.sv
module baud_tick_fsm
    import baud_tick_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_next,
    input  logic             wr_hit,
    input  logic             engines_idle,
    output logic             tick
);

    bt_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;

    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    // Next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (div_next == '0) begin
            state_d = BT_STOPPED;
            cnt_d   = '0;
        end else if (engines_idle) begin
            state_d = BT_PARKED;
            cnt_d   = div_next;
        end else begin
            unique case (state_q)
                BT_STOPPED, BT_PARKED: begin
                    state_d = BT_RUNNING;
                    cnt_d   = div_next;
                end
                BT_RUNNING: begin
                    if (wr_hit || (cnt_q == CNT_ONE)) begin
                        cnt_d = div_next;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                default: begin
                    state_d = BT_STOPPED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BT_STOPPED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Moore output
    always_comb begin
        tick = (state_q == BT_RUNNING) && (cnt_q == CNT_ONE);
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter  int DIV_W = 16,
    localparam int NB    = DIV_W / BYTE_W,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dla_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              engines_idle,
    output logic [BYTE_W-1:0] rd_data,
    output logic              tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_next;
    logic             wr_hit;

    baud_div_regs #(.DIV_W(DIV_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dla_en   (dla_en),
        .wr_en    (wr_en),
        .reg_sel  (reg_sel),
        .wr_data  (wr_data),
        .div_q    (div_q),
        .div_next (div_next),
        .wr_hit   (wr_hit),
        .rd_data  (rd_data)
    );

    baud_tick_fsm #(.DIV_W(DIV_W)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_next     (div_next),
        .wr_hit       (wr_hit),
        .engines_idle (engines_idle),
        .tick         (tick)
    );

endmodule

// File: rtl/baud_tick_checker.sv
module baud_tick_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dla_en,
    input logic             wr_en,
    input logic             engines_idle,
    input logic             tick,
    input logic [DIV_W-1:0] div_q,
    input logic             wr_hit
);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (div_q == '0) && !tick);

    a_r2_zero_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> !tick);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_q > DIV_W'(1)) && !wr_hit) |=> !tick);

    a_r5_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        engines_idle |=> !tick);

    a_r6_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (!tick || (div_q == DIV_W'(1))));

    a_r8_hidden_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dla_en) |=> $stable(div_q));

endmodule

bind baud_tick_gen baud_tick_checker #(.DIV_W(DIV_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dla_en       (dla_en),
    .wr_en        (wr_en),
    .engines_idle (engines_idle),
    .tick         (tick),
    .div_q        (div_q),
    .wr_hit       (wr_hit)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dla_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       engines_idle = 1'b1;
    logic [7:0] rd_data;
    logic       tick;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen i_baud_tick_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .dla_en       (dla_en),
        .wr_en        (wr_en),
        .reg_sel      (reg_sel),
        .wr_data      (wr_data),
        .engines_idle (engines_idle),
        .rd_data      (rd_data),
        .tick         (tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One edge; tick expected when edge count since restart is a multiple of d
    task automatic step_chk(input int d, inout int n, input string req);
        @(posedge clk);
        @(negedge clk);
        n++;
        check(req, int'(tick), (d > 0 && (n % d) == 0) ? 1 : 0);
    endtask

    task automatic step_quiet(input string req);
        @(posedge clk);
        @(negedge clk);
        check(req, int'(tick), 0);
    endtask

    // Accepted write while the engines are idle
    task automatic write_idle(input logic sel, input logic [7:0] data);
        dla_en = 1'b1; wr_en = 1'b1; reg_sel = sel; wr_data = data;
        step_quiet("R5 write while idle");
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input logic sel, input logic dla, input int exp, input string req);
        dla_en = dla; reg_sel = sel;
        #1;
        check(req, int'(rd_data), exp);
        dla_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        int dlist[$];
        repeat (3) @(negedge clk);
        check("R1 tick in reset", int'(tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value on both offsets
        read_chk(1'b0, 1'b1, 0, "R1 low byte after reset");
        read_chk(1'b1, 1'b1, 0, "R1 high byte after reset");
        check("R1 tick after reset", int'(tick), 0);

        // R2 zero divisor with engines active
        engines_idle = 1'b0;
        for (int i = 0; i < 20; i++) step_quiet("R2 zero divisor");
        engines_idle = 1'b1;
        step_quiet("R5 idle");

        // R3/R4 sweep of divisors
        for (int d = 1; d <= 24; d++) dlist.push_back(d);
        dlist.push_back(255); dlist.push_back(256); dlist.push_back(300);
        dlist.push_back(511);
        foreach (dlist[k]) begin
            int d = dlist[k];
            write_idle(1'b0, 8'(d));
            write_idle(1'b1, 8'(d >> 8));
            read_chk(1'b0, 1'b1, d & 255, "R7 low byte readback");
            read_chk(1'b1, 1'b1, d >> 8, "R7 high byte readback");
            engines_idle = 1'b0;
            n = 0;
            for (int c = 0; c < 3 * d + 3; c++) step_chk(d, n, "R3 R4 tick period");
            engines_idle = 1'b1;
            step_quiet("R5 idle after running");
            step_quiet("R5 idle held");
        end

        // R6 reload mid-count with the same divisor
        write_idle(1'b1, 8'h00);
        write_idle(1'b0, 8'd10);
        engines_idle = 1'b0;
        n = 0;
        for (int c = 0; c < 4; c++) step_chk(10, n, "R4 pre-reload");
        dla_en = 1'b1; wr_en = 1'b1; reg_sel = 1'b0; wr_data = 8'd10;
        n = 0;
        step_chk(10, n, "R6 write edge");
        wr_en = 1'b0; dla_en = 1'b0;
        for (int c = 0; c < 25; c++) step_chk(10, n, "R6 phase restart");

        // R6 reload with a new divisor
        dla_en = 1'b1; wr_en = 1'b1; reg_sel = 1'b0; wr_data = 8'd7;
        n = 0;
        step_chk(7, n, "R6 new divisor edge");
        wr_en = 1'b0; dla_en = 1'b0;
        for (int c = 0; c < 5; c++) step_chk(7, n, "R6 new divisor");

        // R8 hidden write keeps phase and value
        dla_en = 1'b0; wr_en = 1'b1; reg_sel = 1'b0; wr_data = 8'd3;
        step_chk(7, n, "R8 hidden write edge");
        reg_sel = 1'b1;
        step_chk(7, n, "R8 hidden write high");
        wr_en = 1'b0;
        for (int c = 0; c < 20; c++) step_chk(7, n, "R8 phase kept");
        read_chk(1'b0, 1'b1, 7, "R8 low byte unchanged");
        read_chk(1'b1, 1'b1, 0, "R8 high byte unchanged");
        read_chk(1'b0, 1'b0, 0, "R7 hidden readback");

        // R2 write zero while running
        dla_en = 1'b1; wr_en = 1'b1; reg_sel = 1'b0; wr_data = 8'd0;
        step_quiet("R2 zero written");
        wr_en = 1'b0; dla_en = 1'b0;
        for (int c = 0; c < 30; c++) step_quiet("R2 stopped");
        engines_idle = 1'b1;
        for (int c = 0; c < 5; c++) step_quiet("R2 stopped idle");
        engines_idle = 1'b0;
        for (int c = 0; c < 5; c++) step_quiet("R2 stopped active");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule